// File: doc/BRIEF.md
# Retire Watchdog with Hot-PC Detector

This block watches the stream of retired instructions from a processor model during simulation. It counts every retirement and records the program counter of each one in a circular history of fixed depth. When a cycle budget runs out, it raises a sticky timeout verdict and freezes what it has seen. It then searches the history for the program counter that appears most often. The result shows where a spinning loop is centred, so a stuck run can be told apart from other ways a run can halt.

The search runs sequentially over the frozen history after the timeout. It compares one candidate entry with every valid entry per pass, using a single read port, so the history can sit in block RAM. A done flag marks when the hot-PC result is final. Only entries written since reset take part, so a short run is never confused by stale memory contents. The cycle budget (`TIMEOUT_CYCLES`, default 5,000,000 cycles, which is 50 ms at 100 MHz), the history depth and all widths are parameters.

Top module: `retire_hotpc_watchdog`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `timeout`, `retire_count`, `hot_done`, `hot_pc` and `hot_count` are all zero.
- R2: `timeout` rises on exactly the `TIMEOUT_CYCLES`-th rising clock edge after reset is released. It then stays high until reset.
- R3: While `timeout` is low, each clock edge with `retire` high adds one to `retire_count`.
- R4: Once `timeout` is high, retire pulses are ignored. `retire_count` stops changing, and no PC retired after that point enters the history or the hot-PC result.
- R5: The history holds the PCs of the last `RING_DEPTH` retirements. The k-th retirement after reset (counting from 0) is stored at ring index k mod `RING_DEPTH` and overwrites the oldest entry.
- R6: After `timeout` rises, `hot_done` eventually rises. `hot_pc` is then the most frequent PC among the valid history entries, and `hot_count` is its number of occurrences.
- R7: When several PCs share the highest count, the one stored at the lowest ring index wins.
- R8: With fewer than `RING_DEPTH` retirements since reset, only the entries written since reset are searched. Memory contents left over from before reset are ignored.
- R9: With no retirements since reset, `hot_done` still rises, with `hot_pc` and `hot_count` both zero.
- R10: `hot_done` is never high while `timeout` is low. After it rises, `hot_pc`, `hot_count` and `hot_done` hold until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | One instruction retires this cycle |
| retire_pc | input | PC_W | PC of the retiring instruction |
| timeout | output | 1 | Sticky cycle-budget-expired verdict |
| retire_count | output | CNT_W | Retirements counted before the timeout |
| hot_done | output | 1 | Hot-PC search finished; result valid |
| hot_pc | output | PC_W | Most frequent PC in the history |
| hot_count | output | $clog2(RING_DEPTH+1) | Occurrences of `hot_pc` in the history |

## Verification
A run with no retirements checks the exact edge on which the timeout rises and the empty-history result. A short burst with a tie checks that tie-breaking goes by ring index, and because it follows a run that filled memory with another PC, it also shows that stale entries are excluded. A run where an early flood of one PC is later overwritten by a mix of two others tells true overwrite apart from a count over all retirements. Random runs draw PCs from a small set at random retire density, then keep retiring a marker PC after the timeout. These show the search agrees with a reference count and that late retirements leave both the counter and the result untouched.

// File: rtl/retire_wd_pkg.sv
package retire_wd_pkg;

  typedef enum logic [2:0] {
    SCAN_IDLE,
    SCAN_RD_CAND,
    SCAN_LD_CAND,
    SCAN_RD_CMP,
    SCAN_CMP,
    SCAN_DONE
  } scan_state_t;

endpackage

// File: rtl/rwd_cycle_timer.sv
module rwd_cycle_timer #(
  parameter int unsigned LIMIT = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic expired_o
);
  localparam int unsigned TW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [TW-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed   <= '0;
      expired_o <= 1'b0;
    end else if (!expired_o) begin
      if (elapsed == TW'(LIMIT - 1)) begin
        expired_o <= 1'b1;
      end else begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end

  // R2: once expired, the verdict persists
  a_r2_expired_sticky: assert property (@(posedge clk) disable iff (rst)
    expired_o |=> expired_o);

  // R2: no expiry while the elapsed count is still short of the budget
  a_r2_not_early: assert property (@(posedge clk) disable iff (rst)
    (!expired_o && elapsed < TW'(LIMIT - 1)) |=> !expired_o);

endmodule

// File: rtl/rwd_pc_ring.sv
module rwd_pc_ring #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [PC_W-1:0]            wr_pc,
  input  logic                       rd_en,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [PC_W-1:0]            rd_data,
  output logic [$clog2(DEPTH+1)-1:0] valid_cnt
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned VW = $clog2(DEPTH + 1);

  logic [PC_W-1:0] store [DEPTH];
  logic [IW-1:0]   wr_ptr;

  // storage and read port without reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= wr_pc;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      valid_cnt <= '0;
    end else if (wr_en) begin
      wr_ptr <= (wr_ptr == IW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (valid_cnt != VW'(DEPTH)) valid_cnt <= valid_cnt + 1'b1;
    end
  end

  // R5: valid count never exceeds the ring depth
  a_r5_valid_bound: assert property (@(posedge clk) disable iff (rst)
    valid_cnt <= VW'(DEPTH));

  // R5: each write to a not-yet-full ring adds one valid entry
  a_r5_valid_grows: assert property (@(posedge clk) disable iff (rst)
    (wr_en && valid_cnt != VW'(DEPTH)) |=> valid_cnt == $past(valid_cnt) + 1'b1);

  // R5: while filling, the write pointer tracks the number of entries
  a_r5_ptr_tracks: assert property (@(posedge clk) disable iff (rst)
    (valid_cnt != VW'(DEPTH)) |-> (VW'(wr_ptr) == valid_cnt));

endmodule

// File: rtl/rwd_hot_scan.sv
module rwd_hot_scan
  import retire_wd_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [$clog2(DEPTH+1)-1:0] valid_cnt_i,
  output logic                       rd_en_o,
  output logic [$clog2(DEPTH)-1:0]   rd_addr_o,
  input  logic [PC_W-1:0]            rd_data_i,
  output logic                       hot_done_o,
  output logic [PC_W-1:0]            hot_pc_o,
  output logic [$clog2(DEPTH+1)-1:0] hot_count_o
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned VW = $clog2(DEPTH + 1);

  scan_state_t     state;
  logic [IW-1:0]   cand_idx;
  logic [IW-1:0]   cmp_idx;
  logic [PC_W-1:0] cand_pc;
  logic [VW-1:0]   run_cnt;
  logic [PC_W-1:0] best_pc;
  logic [VW-1:0]   best_cnt;

  logic [VW-1:0]   last_idx;
  logic [VW-1:0]   tally;
  logic            better;
  logic [PC_W-1:0] next_best_pc;
  logic [VW-1:0]   next_best_cnt;

  always_comb begin
    last_idx      = valid_cnt_i - 1'b1;
    tally         = run_cnt + VW'(rd_data_i == cand_pc);
    // strictly greater keeps the earliest candidate on ties
    better        = tally > best_cnt;
    next_best_pc  = better ? cand_pc : best_pc;
    next_best_cnt = better ? tally   : best_cnt;
    rd_en_o       = (state == SCAN_RD_CAND) || (state == SCAN_RD_CMP);
    rd_addr_o     = (state == SCAN_RD_CAND) ? cand_idx : cmp_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SCAN_IDLE;
      cand_idx    <= '0;
      cmp_idx     <= '0;
      cand_pc     <= '0;
      run_cnt     <= '0;
      best_pc     <= '0;
      best_cnt    <= '0;
      hot_done_o  <= 1'b0;
      hot_pc_o    <= '0;
      hot_count_o <= '0;
    end else begin
      unique case (state)
        SCAN_IDLE: begin
          if (start_i) begin
            cand_idx <= '0;
            best_pc  <= '0;
            best_cnt <= '0;
            if (valid_cnt_i == '0) begin
              hot_done_o <= 1'b1;
              state      <= SCAN_DONE;
            end else begin
              state <= SCAN_RD_CAND;
            end
          end
        end
        SCAN_RD_CAND: state <= SCAN_LD_CAND;
        SCAN_LD_CAND: begin
          cand_pc <= rd_data_i;
          cmp_idx <= '0;
          run_cnt <= '0;
          state   <= SCAN_RD_CMP;
        end
        SCAN_RD_CMP: state <= SCAN_CMP;
        SCAN_CMP: begin
          if (VW'(cmp_idx) == last_idx) begin
            best_pc  <= next_best_pc;
            best_cnt <= next_best_cnt;
            if (VW'(cand_idx) == last_idx) begin
              hot_pc_o    <= next_best_pc;
              hot_count_o <= next_best_cnt;
              hot_done_o  <= 1'b1;
              state       <= SCAN_DONE;
            end else begin
              cand_idx <= cand_idx + 1'b1;
              state    <= SCAN_RD_CAND;
            end
          end else begin
            run_cnt <= tally;
            cmp_idx <= cmp_idx + 1'b1;
            state   <= SCAN_RD_CMP;
          end
        end
        SCAN_DONE: state <= SCAN_DONE;
        default:   state <= SCAN_IDLE;
      endcase
    end
  end

  // R10: a result is only published after the timeout
  a_r10_done_needs_timeout: assert property (@(posedge clk) disable iff (rst)
    hot_done_o |-> start_i);

  // R10: the published result holds
  a_r10_result_holds: assert property (@(posedge clk) disable iff (rst)
    hot_done_o |=> (hot_done_o && $stable(hot_pc_o) && $stable(hot_count_o)));

  // R6: a reported count cannot exceed the valid entries
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    hot_done_o |-> hot_count_o <= valid_cnt_i);

  // R9: zero count exactly when the history is empty
  a_r9_empty_zero: assert property (@(posedge clk) disable iff (rst)
    hot_done_o |-> ((hot_count_o == '0) == (valid_cnt_i == '0)));

  // R8: reads stay within the valid part of the history
  a_r8_read_in_range: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |-> VW'(rd_addr_o) < valid_cnt_i);

endmodule

// File: rtl/retire_hotpc_watchdog.sv
module retire_hotpc_watchdog #(
  parameter int unsigned PC_W           = 32,
  parameter int unsigned CNT_W          = 32,
  parameter int unsigned RING_DEPTH     = 256,
  parameter int unsigned TIMEOUT_CYCLES = 5_000_000
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            retire,
  input  logic [PC_W-1:0]                 retire_pc,
  output logic                            timeout,
  output logic [CNT_W-1:0]                retire_count,
  output logic                            hot_done,
  output logic [PC_W-1:0]                 hot_pc,
  output logic [$clog2(RING_DEPTH+1)-1:0] hot_count
);
  localparam int unsigned IW = $clog2(RING_DEPTH);
  localparam int unsigned VW = $clog2(RING_DEPTH + 1);

  logic            take;
  logic            rd_en;
  logic [IW-1:0]   rd_addr;
  logic [PC_W-1:0] rd_data;
  logic [VW-1:0]   valid_cnt;

  assign take = retire && !timeout;

  rwd_cycle_timer #(
    .LIMIT (TIMEOUT_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .expired_o (timeout)
  );

  always_ff @(posedge clk) begin
    if (rst)       retire_count <= '0;
    else if (take) retire_count <= retire_count + 1'b1;
  end

  rwd_pc_ring #(
    .PC_W  (PC_W),
    .DEPTH (RING_DEPTH)
  ) u_ring (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (take),
    .wr_pc     (retire_pc),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .valid_cnt (valid_cnt)
  );

  rwd_hot_scan #(
    .PC_W  (PC_W),
    .DEPTH (RING_DEPTH)
  ) u_scan (
    .clk         (clk),
    .rst         (rst),
    .start_i     (timeout),
    .valid_cnt_i (valid_cnt),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .hot_done_o  (hot_done),
    .hot_pc_o    (hot_pc),
    .hot_count_o (hot_count)
  );

  // R3: one step per accepted retirement
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    (retire && !timeout) |=> retire_count == $past(retire_count) + 1'b1);

  // R3: no step without a retirement
  a_r3_count_idle: assert property (@(posedge clk) disable iff (rst)
    (!retire) |=> $stable(retire_count));

  // R4: counter frozen after the verdict
  a_r4_count_frozen: assert property (@(posedge clk) disable iff (rst)
    timeout |=> $stable(retire_count));

  // R4: history frozen after the verdict
  a_r4_ring_frozen: assert property (@(posedge clk) disable iff (rst)
    timeout |=> $stable(valid_cnt));

endmodule

// File: tb/retire_hotpc_watchdog_bench.sv
module retire_hotpc_watchdog_bench;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned LIMIT = 400;
  localparam int unsigned VW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst;
  logic             retire;
  logic [PC_W-1:0]  retire_pc;
  logic             timeout;
  logic [CNT_W-1:0] retire_count;
  logic             hot_done;
  logic [PC_W-1:0]  hot_pc;
  logic [VW-1:0]    hot_count;

  int checks = 0;
  int errors = 0;

  logic [31:0] mring [DEPTH];
  int          mptr;
  int          mvalid;
  longint      mtotal;

  always #4 clk = ~clk;

  retire_hotpc_watchdog #(
    .PC_W (PC_W), .CNT_W (CNT_W), .RING_DEPTH (DEPTH), .TIMEOUT_CYCLES (LIMIT)
  ) u_retire_hotpc_watchdog (
    .clk (clk), .rst (rst), .retire (retire), .retire_pc (retire_pc),
    .timeout (timeout), .retire_count (retire_count), .hot_done (hot_done),
    .hot_pc (hot_pc), .hot_count (hot_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void expect_hot(output logic [31:0] pc, output int cnt);
    pc  = '0;
    cnt = 0;
    for (int i = 0; i < mvalid; i++) begin
      int c = 0;
      for (int j = 0; j < mvalid; j++) if (mring[j] == mring[i]) c++;
      if (c > cnt) begin cnt = c; pc = mring[i]; end
    end
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; retire = 1'b0; retire_pc = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mptr = 0; mvalid = 0; mtotal = 0;
  endtask

  // drives one cycle; the model accepts it only if timeout is low before the edge
  task automatic step(input bit ret, input logic [31:0] pc);
    @(negedge clk);
    if (ret && !timeout) begin
      mring[mptr] = pc;
      mptr = (mptr + 1) % DEPTH;
      if (mvalid < DEPTH) mvalid++;
      mtotal++;
    end
    retire = ret; retire_pc = pc;
  endtask

  task automatic idle_to_timeout();
    int n = 0;
    while (!timeout && n < LIMIT + 10) begin step(1'b0, '0); n++; end
    @(negedge clk); retire = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!hot_done && n < 20000) begin @(negedge clk); n++; end
    check(hot_done, req, "hot_done", longint'(hot_done), 1);
  endtask

  task automatic check_result(input string req);
    logic [31:0] epc;
    int          ecnt;
    expect_hot(epc, ecnt);
    wait_done(req);
    check(hot_pc == epc, req, "hot_pc", hot_pc, epc);
    check(int'(hot_count) == ecnt, req, "hot_count", hot_count, ecnt);
    check(retire_count == CNT_W'(mtotal), "R3", "retire_count", retire_count, mtotal);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; retire = 1'b0; retire_pc = '0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(!timeout && retire_count == 0 && !hot_done && hot_pc == 0 && hot_count == 0,
          "R1", "outputs in reset", {timeout, hot_done}, 0);
    rst = 1'b0; mptr = 0; mvalid = 0; mtotal = 0;
    @(negedge clk);
    check(!timeout && retire_count == 0 && !hot_done, "R1", "after release",
          {timeout, hot_done}, 0);

    // R2 / R9 / R10: no retires; exact expiry edge (one edge already elapsed)
    repeat (LIMIT - 2) @(negedge clk);
    check(!timeout, "R2", "timeout before budget", timeout, 0);
    check(!hot_done, "R10", "done before timeout", hot_done, 0);
    @(negedge clk);
    check(timeout, "R2", "timeout at budget edge", timeout, 1);
    wait_done("R9");
    check(hot_pc == 0 && hot_count == 0, "R9", "empty result", hot_count, 0);
    repeat (5) @(negedge clk);
    check(timeout, "R2", "timeout sticky", timeout, 1);
    check(hot_done && hot_pc == 0, "R10", "result held", hot_done, 1);

    // R5: early flood overwritten by a later mix
    do_reset();
    for (int k = 0; k < 20; k++) step(1'b1, 32'hC0DE);
    for (int k = 0; k < 16; k++) step(1'b1, (k % 8 < 5) ? 32'h200 : 32'h300);
    step(1'b0, '0);
    @(negedge clk);
    check(retire_count == 36, "R3", "directed count", retire_count, 36);
    idle_to_timeout();
    wait_done("R5");
    check(hot_pc == 32'h200, "R5", "overwrite hot_pc", hot_pc, 32'h200);
    check(hot_count == 10, "R5", "overwrite hot_count", hot_count, 10);

    // R7 / R8: short run with a tie over stale memory
    do_reset();
    step(1'b1, 32'h100); step(1'b1, 32'h104); step(1'b1, 32'h104);
    step(1'b1, 32'h108); step(1'b1, 32'h100);
    idle_to_timeout();
    wait_done("R8");
    check(hot_pc == 32'h100, "R7", "tie goes to lowest index", hot_pc, 32'h100);
    check(hot_count == 2, "R8", "only valid entries", hot_count, 2);

    // R4 / R6: random runs, then marker retires after the verdict
    for (int run = 0; run < 3; run++) begin
      longint frozen;
      do_reset();
      while (!timeout) begin
        step(($urandom % 3) != 0, 32'h1000 + 4 * ($urandom % 5));
        if (mtotal == 50) begin
          @(negedge clk); retire = 1'b0;
          check(retire_count == 50, "R3", "mid-run count", retire_count, 50);
        end
      end
      frozen = mtotal;
      for (int k = 0; k < 20; k++) step(1'b1, 32'hDEAD);
      @(negedge clk); retire = 1'b0;
      check(retire_count == CNT_W'(frozen), "R4", "count frozen", retire_count, frozen);
      check_result("R6");
      check(hot_pc != 32'hDEAD, "R4", "late pc excluded", hot_pc, 32'h1000);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule